// File: doc/BRIEF.md
# Vectored Interrupt Controller with Per-Input Trigger Selection

This block gathers up to 32 interrupt request lines into a single processor interrupt. Each line is captured into a sticky status register. A build-time mask chooses, for each line, whether it is captured by its level or by its rising edge. The status register is masked by an enable register to give the pending set. The controller reports the number of the lowest pending line as a vector. It raises its one output to the processor whenever pending is nonzero and the output gate is open.

Software reaches eight 32-bit registers through a simple synchronous word bus. The bus address is the word offset, so the byte address is four times the offset, and every access is a full word. Writes take effect at the clock edge on which `bus_sel` and `bus_we` are both high. Read data is combinational from the addressed register.

A two-bit master register carries two controls. Bit 0 opens the output gate. Bit 1 switches on hardware capture of the request lines. Before capture is switched on, software may write the status register directly to raise test interrupts. Once capture is on, those writes are dropped. Write-one-to-act offsets acknowledge status bits and set or clear enable bits, so software never needs a read-modify-write sequence.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Word offsets are: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 enable-set, 5 enable-clear, 6 vector, 7 master. After reset every register reads zero, except the vector, which reads 0xFFFFFFFF. Offsets 3, 4 and 5 always read zero.
- R2: Pending reads as status AND enable. Writes to the pending offset have no effect, and neither do writes to the vector offset.
- R3: The vector reads as the index (0 to 31) of the lowest set bit of pending. When pending is zero, it reads 0xFFFFFFFF.
- R4: A write to the acknowledge offset clears every status bit whose written bit is 1 and leaves the other status bits unchanged.
- R5: A write to enable-set ORs the written value into enable. A write to enable-clear clears the enable bits where the value has 1s. A write to the enable offset replaces enable.
- R6: The master register keeps only bits [1:0] of a write. Bits [31:2] read zero.
- R7: `irq_out` is 1 exactly when master bit 0 is 1 and pending is nonzero. It follows register state combinationally.
- R8: When master bit 1 is 1, a level-type line that is high at a clock edge sets its status bit at that edge. A line that stays high sets the bit again after an acknowledge.
- R9: When master bit 1 is 1, an edge-type line sets its status bit only on a low-to-high change between consecutive clock edges. Holding the line high does not set the bit again after an acknowledge.
- R10: A software write to the status offset replaces status only while master bit 1 is 0. While master bit 1 is 1, the write is ignored.
- R11: If a line sets its status bit in the same cycle that an acknowledge clears that bit, the bit ends up set.
- R12: While master bit 1 is 0, the request lines do not change status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_word | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_in | input | 32 | Request lines, synchronous to clk |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
Register writes and line captures land at the clock edge that samples them. Read data, pending, vector and `irq_out` are combinational from the registers. Every result is therefore due one edge after its stimulus. The bench drives each stimulus on a falling edge and reads results on the next falling edge, half a period after the register update. For the same-cycle acknowledge case, the line change and the acknowledge are launched on one falling edge, so that both reach the same rising edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned NUM_SRC = 32;
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);

    typedef enum logic [2:0] {
        OFS_STATUS = 3'd0,
        OFS_PEND   = 3'd1,
        OFS_ENA    = 3'd2,
        OFS_ACK    = 3'd3,
        OFS_SETEN  = 3'd4,
        OFS_CLREN  = 3'd5,
        OFS_VEC    = 3'd6,
        OFS_MASTER = 3'd7
    } ofs_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] enable;
        logic [1:0]         master;
        logic [NUM_SRC-1:0] in_prev;
    } state_t;

endpackage

// File: rtl/ivc_trigger.sv
module ivc_trigger #(
    parameter int unsigned N         = 32,
    parameter logic [N-1:0] EDGE_MASK = '0
) (
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] in_prev,
    input  logic         latch_en,
    output logic [N-1:0] hit
);
    for (genvar i = 0; i < N; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            assign hit[i] = latch_en & irq_in[i] & ~in_prev[i];
        end else begin : g_level
            assign hit[i] = latch_en & irq_in[i];
        end
    end
endmodule

// File: rtl/ivc_lowest.sv
module ivc_lowest #(
    parameter int unsigned N = 32,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic              irq_out
);

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] pend;
    logic               any_found;
    logic [IDX_W-1:0]   low_idx;
    logic [DATA_W-1:0]  vec;
    logic               wr_en;
    ofs_e               ofs;

    assign ofs   = ofs_e'(bus_word);
    assign wr_en = bus_sel & bus_we;

    ivc_trigger #(
        .N        (NUM_SRC),
        .EDGE_MASK(EDGE_MASK)
    ) u_trig (
        .irq_in  (irq_in),
        .in_prev (st_q.in_prev),
        .latch_en(st_q.master[1]),
        .hit     (hit)
    );

    assign pend = st_q.status & st_q.enable;

    ivc_lowest #(
        .N(NUM_SRC)
    ) u_low (
        .req  (pend),
        .found(any_found),
        .idx  (low_idx)
    );

    assign vec     = any_found ? DATA_W'(low_idx) : '1;
    assign irq_out = st_q.master[0] & any_found;

    // next-state computation
    always_comb begin
        st_d         = st_q;
        st_d.in_prev = irq_in;
        if (wr_en) begin
            case (ofs)
                OFS_STATUS: if (!st_q.master[1]) st_d.status = bus_wdata;
                OFS_ENA:    st_d.enable = bus_wdata;
                OFS_ACK:    st_d.status = st_q.status & ~bus_wdata;
                OFS_SETEN:  st_d.enable = st_q.enable | bus_wdata;
                OFS_CLREN:  st_d.enable = st_q.enable & ~bus_wdata;
                OFS_MASTER: st_d.master = bus_wdata[1:0];
                default:    ;
            endcase
        end
        // a capture in the same cycle overrides an acknowledge
        st_d.status = st_d.status | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        case (ofs)
            OFS_STATUS: bus_rdata = st_q.status;
            OFS_PEND:   bus_rdata = pend;
            OFS_ENA:    bus_rdata = st_q.enable;
            OFS_VEC:    bus_rdata = vec;
            OFS_MASTER: bus_rdata = {30'd0, st_q.master};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
    import ivc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [2:0]         bus_word,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [1:0]         master_q,
    input logic [NUM_SRC-1:0] pend,
    input logic [DATA_W-1:0]  vec,
    input logic               irq_out
);
    logic wr;
    assign wr = bus_sel & bus_we;

    assert_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_word == 3'd7) |=> master_q == $past(bus_wdata[1:0]));

    assert_set_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_word == 3'd4) |=> enable_q == ($past(enable_q) | $past(bus_wdata)));

    assert_clr_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_word == 3'd5) |=> enable_q == ($past(enable_q) & ~$past(bus_wdata)));

    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (bus_word == 3'd3 || bus_word == 3'd0)) |=>
        (status_q & $past(status_q)) == $past(status_q));

    assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !master_q[0] |-> !irq_out);

    assert_vec_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != '1) |-> (pend[vec[IDX_W-1:0]] &&
                         ((pend & ((NUM_SRC'(1) << vec[IDX_W-1:0]) - NUM_SRC'(1))) == '0)));

    assert_vec_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == '1) |-> (pend == '0));
endmodule

bind irq_vec_ctrl ivc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_word (bus_word),
    .bus_wdata(bus_wdata),
    .status_q (st_q.status),
    .enable_q (st_q.enable),
    .master_q (st_q.master),
    .pend     (pend),
    .vec      (vec),
    .irq_out  (irq_out)
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;

    localparam logic [31:0] EDGES = 32'hFFFF_0000;
    localparam int NV = 7;
    // {status written, enable written, expected vector}
    localparam logic [95:0] VEC_TAB [NV] = '{
        {32'hFFFF_FFFF, 32'h0000_0001, 32'd0},
        {32'h0000_0008, 32'hFFFF_FFFF, 32'd3},
        {32'h8000_0000, 32'h8000_0000, 32'd31},
        {32'hF0F0_0000, 32'h0F0F_0000, 32'hFFFF_FFFF},
        {32'h00A0_0000, 32'h00FF_FF00, 32'd21},
        {32'h1234_5678, 32'h0000_0000, 32'hFFFF_FFFF},
        {32'h0001_0100, 32'h0001_0000, 32'd16}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [2:0]  bus_word = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [31:0] irq_in = 0;
    logic        irq_out;
    int          n_run = 0, n_fail = 0;
    logic        done = 0;
    logic [31:0] r;

    always #10 clk = ~clk;

    irq_vec_ctrl #(.EDGE_MASK(EDGES)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] d);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), r);
            check("R1 reset read", r, (i == 6) ? 32'hFFFF_FFFF : 32'h0);
        end
        check("R7 reset irq_out", {31'd0, irq_out}, 32'd0);

        // table walk: master = 1 (gate open, capture off)
        wr(3'd7, 32'h1);
        for (int k = 0; k < NV; k++) begin
            logic [31:0] s, e, v;
            {s, e, v} = VEC_TAB[k];
            wr(3'd0, s);
            wr(3'd2, e);
            wr(3'd1, 32'h0);
            wr(3'd6, 32'h0);
            rd(3'd1, r); check("R2 pending", r, s & e);
            rd(3'd6, r); check("R3 vector", r, v);
            check("R7 irq_out", {31'd0, irq_out}, {31'd0, (s & e) != 0});
        end

        // R1 write-to-act offsets read zero; R5 set/clear
        wr(3'd2, 32'h0000_00F0);
        wr(3'd4, 32'h0000_000F);
        rd(3'd2, r); check("R5 enable-set", r, 32'h0000_00FF);
        wr(3'd5, 32'h0000_0081);
        rd(3'd2, r); check("R5 enable-clear", r, 32'h0000_007E);
        rd(3'd3, r); check("R1 ack reads 0", r, 0);
        rd(3'd4, r); check("R1 set reads 0", r, 0);
        rd(3'd5, r); check("R1 clr reads 0", r, 0);

        // R4 acknowledge
        wr(3'd0, 32'hF0F0_F0F0);
        wr(3'd3, 32'h3000_00F0);
        rd(3'd0, r); check("R4 ack", r, 32'hC0F0_F000);

        // R6 master bits
        wr(3'd7, 32'hFFFF_FFFC);
        rd(3'd7, r); check("R6 master upper dropped", r, 0);
        // R7 gate closed with pending present
        wr(3'd2, 32'hFFFF_FFFF);
        check("R7 gate closed", {31'd0, irq_out}, 0);

        // R12 capture off: lines ignored
        wr(3'd3, 32'hFFFF_FFFF);
        @(negedge clk); irq_in = 32'h0001_0004;
        repeat (2) @(negedge clk);
        rd(3'd0, r); check("R12 lines ignored", r, 0);
        irq_in = 0;
        @(negedge clk);

        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, r); check("R6 master keeps 3", r, 32'h3);

        // R10 status write ignored while capturing
        wr(3'd0, 32'h0000_5555);
        rd(3'd0, r); check("R10 status write ignored", r, 0);

        // R8 level capture
        @(negedge clk); irq_in = 32'h1;
        @(negedge clk); irq_in = 32'h0;
        rd(3'd0, r); check("R8 level latched", r, 32'h1);
        check("R7 irq_out on", {31'd0, irq_out}, 1);
        rd(3'd6, r); check("R3 vector level", r, 0);
        wr(3'd3, 32'h1);
        rd(3'd0, r); check("R4 ack level low", r, 0);
        @(negedge clk); irq_in = 32'h2;
        @(negedge clk);
        wr(3'd3, 32'h2);
        rd(3'd0, r); check("R8 level held resets", r, 32'h2);
        irq_in = 0;
        wr(3'd3, 32'h2);
        rd(3'd0, r); check("R8 cleared after drop", r, 0);

        // R9 edge capture
        @(negedge clk); irq_in = 32'h0001_0000;
        @(negedge clk);
        rd(3'd0, r); check("R9 edge latched", r, 32'h0001_0000);
        wr(3'd3, 32'h0001_0000);
        @(negedge clk);
        rd(3'd0, r); check("R9 held high no reset", r, 0);

        // R11 capture beats acknowledge
        irq_in = 0;
        @(negedge clk); irq_in = 32'h0002_0000;
        @(negedge clk); irq_in = 0;
        rd(3'd0, r); check("R9 second edge", r, 32'h0002_0000);
        @(negedge clk);
        irq_in = 32'h0002_0000;
        bus_sel = 1; bus_we = 1; bus_word = 3'd3; bus_wdata = 32'h0002_0000;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        rd(3'd0, r); check("R11 set wins over ack", r, 32'h0002_0000);
        rd(3'd6, r); check("R3 vector edge", r, 32'd17);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule